// File: doc/BRIEF.md
# GPIO Bank Register File

This block is the register file of one general-purpose I/O bank of up to 32 pins. It holds an output latch, a per-pin direction bit and a two-bit function selector for each pin. It also returns the live, synchronized pin levels over a simple word-addressed register bus. Software raises or lowers individual outputs by writing a mask to a dedicated set or clear register. Other pins are left untouched, so no read-modify-write sequence is needed.

The pad-facing side drives an output enable and an output level per pin. It exposes the selector codes so that a pin multiplexer outside this block can route other functions to the pad. The `NUM_PINS` parameter builds a partial bank, such as a 21-pin last bank. Pins at or above that index are not implemented.

Top module: `gpio_bank_regs`

## Requirements
- R1: A write to the set register (word address 0x2) drives high the output latch of every pin whose write-data bit is 1. Pins written as 0 keep their latch value. The change is visible on `pad_out` after the clock edge that accepts the write.
- R2: A write to the clear register (word address 0x3) drives low the output latch of every pin whose write-data bit is 1. Pins written as 0 keep their latch value.
- R3: The direction register (word address 0x1) is read-write. Bit n = 1 makes pin n an output (`pad_oe[n]` = 1), and bit n = 0 makes it an input. It reads back the value that is driven on `pad_oe`.
- R4: The level register (word address 0x0) is read-only. It returns `pad_in` after a two-flop synchronizer: a pin change made between edges is not visible in a read after one clock edge, and it is visible after the second edge. Writes to it have no effect.
- R5: Each pin has a 2-bit function code. Pin n uses bits [2*(n mod 16)+1 : 2*(n mod 16)] of the selector-low register (word address 0x4) when n < 16, and of the selector-high register (word address 0x5) otherwise. Both registers are read-write, and the code for pin n appears on `alt_sel[2n+1:2n]`.
- R6: Pins with index ≥ `NUM_PINS` read as 0 in every register, ignore writes, and drive 0 on `pad_oe`, `pad_out` and `alt_sel`.
- R7: The set and clear registers always read as 0.
- R8: After reset, all pins are inputs, all output latches are 0 and all function codes are 0.
- R9: The output latch changes only through a write to the set or clear register. It is driven on `pad_out` whatever the pin's direction.
- R10: Reads of word addresses 0x6 to 0xF return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address of the register |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pin levels from the pads |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin output level |
| alt_sel | output | 64 | Per-pin 2-bit function code, pin n at [2n+1:2n] |

## Verification
A stuck or mis-decoded output latch shows on `pad_out` at the first negative edge after the accepting write, because the latch feeds the pad directly. A wrong bit lane in a set/clear mask also shows there at once. Direction and selector errors appear both on their pad outputs and in the same-cycle read-back, so a mismatch between the two points to the read mux. A synchronizer that is too short or too long shifts the level read by a whole cycle; the bench reads level one cycle and two cycles after a pin change to catch it. A broken pin-count mask shows up as nonzero upper bits in any register of a 21-pin bank.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BANK_W       = 32;
    localparam int CODE_W       = 2;
    localparam int PINS_PER_SEL = 16;
    localparam int SEL_W        = BANK_W * CODE_W;
    localparam int ADDR_W       = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_LEVEL  = 4'h0,
        REG_DIR    = 4'h1,
        REG_SET    = 4'h2,
        REG_CLR    = 4'h3,
        REG_ALT_LO = 4'h4,
        REG_ALT_HI = 4'h5
    } reg_sel_e;

    typedef struct packed {
        logic set_hit;
        logic clr_hit;
        logic dir_hit;
        logic alt_lo_hit;
        logic alt_hi_hit;
    } wr_dec_t;

    function automatic logic [BANK_W-1:0] pin_mask(input int n);
        logic [BANK_W-1:0] m;
        for (int i = 0; i < BANK_W; i++) m[i] = (i < n);
        return m;
    endfunction

    function automatic logic [SEL_W-1:0] code_mask(input int n);
        logic [SEL_W-1:0] m;
        for (int i = 0; i < SEL_W; i++) m[i] = (i < CODE_W * n);
        return m;
    endfunction

    function automatic wr_dec_t decode_wr(input logic wr, input logic [ADDR_W-1:0] addr);
        wr_dec_t d;
        d.set_hit    = wr && (addr == REG_SET);
        d.clr_hit    = wr && (addr == REG_CLR);
        d.dir_hit    = wr && (addr == REG_DIR);
        d.alt_lo_hit = wr && (addr == REG_ALT_LO);
        d.alt_hi_hit = wr && (addr == REG_ALT_HI);
        return d;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Synchronizer flops carry no reset; they track the pins in every cycle.
    always_ff @(posedge clk) begin
        stage1_q <= async_in;
        stage2_q <= stage1_q;
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_out_ctrl.sv
module gpio_out_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_dec_t           dec,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] out_q,
    output logic [BANK_W-1:0] dir_q
);
    localparam logic [BANK_W-1:0] IMPL = pin_mask(NUM_PINS);

    logic [BANK_W-1:0] set_bits;
    logic [BANK_W-1:0] clr_bits;

    always_comb begin
        set_bits = dec.set_hit ? (wdata & IMPL) : '0;
        clr_bits = dec.clr_hit ? (wdata & IMPL) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
        end else begin
            // Clear wins over set should both ever hit the same bit.
            out_q <= (out_q | set_bits) & ~clr_bits;
            if (dec.dir_hit) dir_q <= wdata & IMPL;
        end
    end
endmodule

// File: rtl/gpio_alt_sel.sv
module gpio_alt_sel
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_dec_t           dec,
    input  logic [BANK_W-1:0] wdata,
    output logic [SEL_W-1:0]  codes
);
    for (genvar p = 0; p < BANK_W; p++) begin : g_pin
        localparam int LANE = CODE_W * (p % PINS_PER_SEL);
        if (p < NUM_PINS) begin : g_impl
            logic [CODE_W-1:0] code_q;
            logic              hit;
            assign hit = (p < PINS_PER_SEL) ? dec.alt_lo_hit : dec.alt_hi_hit;
            always_ff @(posedge clk) begin
                if (rst)      code_q <= '0;
                else if (hit) code_q <= wdata[LANE +: CODE_W];
            end
            assign codes[CODE_W*p +: CODE_W] = code_q;
        end else begin : g_absent
            assign codes[CODE_W*p +: CODE_W] = '0;
        end
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    input  logic [BANK_W-1:0] pad_in,
    output logic [BANK_W-1:0] pad_oe,
    output logic [BANK_W-1:0] pad_out,
    output logic [SEL_W-1:0]  alt_sel
);
    localparam logic [BANK_W-1:0] IMPL = pin_mask(NUM_PINS);

    wr_dec_t           dec;
    logic [BANK_W-1:0] level;
    logic [BANK_W-1:0] out_q;
    logic [BANK_W-1:0] dir_q;
    logic [SEL_W-1:0]  codes;

    assign dec = decode_wr(bus_wr, bus_addr);

    gpio_in_sync #(.WIDTH(BANK_W)) u_sync (
        .clk(clk), .async_in(pad_in), .sync_out(level)
    );

    gpio_out_ctrl #(.NUM_PINS(NUM_PINS)) u_out (
        .clk(clk), .rst(rst), .dec(dec), .wdata(bus_wdata),
        .out_q(out_q), .dir_q(dir_q)
    );

    gpio_alt_sel #(.NUM_PINS(NUM_PINS)) u_alt (
        .clk(clk), .rst(rst), .dec(dec), .wdata(bus_wdata), .codes(codes)
    );

    always_comb begin
        case (bus_addr)
            REG_LEVEL:  bus_rdata = level & IMPL;
            REG_DIR:    bus_rdata = dir_q;
            REG_ALT_LO: bus_rdata = codes[BANK_W-1:0];
            REG_ALT_HI: bus_rdata = codes[SEL_W-1:BANK_W];
            default:    bus_rdata = '0;
        endcase
    end

    assign pad_oe  = dir_q;
    assign pad_out = out_q;
    assign alt_sel = codes;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BANK_W-1:0] bus_wdata,
    input logic [BANK_W-1:0] bus_rdata,
    input logic [BANK_W-1:0] pad_in,
    input logic [BANK_W-1:0] pad_oe,
    input logic [BANK_W-1:0] pad_out,
    input logic [SEL_W-1:0]  alt_sel
);
    localparam logic [BANK_W-1:0] IMPL  = pin_mask(NUM_PINS);
    localparam logic [SEL_W-1:0]  CIMPL = code_mask(NUM_PINS);

    a_r1_set_raises: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_SET) |=>
        ((pad_out & $past(bus_wdata) & IMPL) == ($past(bus_wdata) & IMPL)));

    a_r2_clr_lowers: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_CLR) |=> ((pad_out & $past(bus_wdata)) == '0));

    a_r3_dir_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_DIR) |-> (bus_rdata == pad_oe));

    a_r4_level_two_flops: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_LEVEL) |-> (bus_rdata == ($past(pad_in, 2) & IMPL)));

    a_r5_alt_lo_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_ALT_LO) |-> (bus_rdata == alt_sel[BANK_W-1:0]));

    a_r6_absent_quiet: assert property (@(posedge clk) disable iff (rst)
        (((pad_oe | pad_out) & ~IMPL) == '0) && ((alt_sel & ~CIMPL) == '0));

    a_r7_strobe_regs_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_SET || bus_addr == REG_CLR) |-> (bus_rdata == '0));

    a_r8_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0 && alt_sel == '0));

    a_r9_latch_holds: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (bus_addr == REG_SET || bus_addr == REG_CLR)) |=> $stable(pad_out));
endmodule

bind gpio_bank_regs gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .alt_sel(alt_sel)
);

// File: tb/tb_gpio_bank_regs.sv
module tb_gpio_bank_regs;
    localparam int PINS = 21;
    localparam logic [31:0] IMPL = 32'h001F_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;
    logic [63:0] alt_sel;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_out = '0;

    always #4 clk = ~clk;

    gpio_bank_regs #(.NUM_PINS(PINS)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .alt_sel(alt_sel)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R8 pad_oe", pad_oe, 0);
        check("R8 pad_out", pad_out, 0);
        check("R8 alt_sel", alt_sel, 0);
        bus_read(4'h1, r); check("R8 dir read", r, 0);
    endtask

    task automatic t_set_clear();
        bus_write(4'h2, 32'h0000_00A5); exp_out = 32'h0000_00A5;
        check("R1 set", pad_out, exp_out);
        bus_write(4'h2, 32'h0000_0100); exp_out = 32'h0000_01A5;
        check("R1 zeros keep", pad_out, exp_out);
        bus_write(4'h3, 32'h0000_0005); exp_out = 32'h0000_01A0;
        check("R2 clear", pad_out, exp_out);
        bus_write(4'h3, 32'h0000_0000);
        check("R2 zeros keep", pad_out, exp_out);
    endtask

    task automatic t_dir_hold();
        logic [31:0] r;
        bus_write(4'h1, 32'h000F_0F0F);
        check("R3 pad_oe", pad_oe, 32'h000F_0F0F);
        bus_read(4'h1, r); check("R3 readback", r, 32'h000F_0F0F);
        check("R9 latch after dir write", pad_out, exp_out);
        repeat (3) @(negedge clk);
        check("R9 latch idle", pad_out, exp_out);
    endtask

    task automatic t_read_zero();
        logic [31:0] r;
        bus_read(4'h2, r); check("R7 set reads 0", r, 0);
        bus_read(4'h3, r); check("R7 clr reads 0", r, 0);
        bus_read(4'h7, r); check("R10 addr 7", r, 0);
        bus_read(4'hF, r); check("R10 addr F", r, 0);
    endtask

    task automatic t_level();
        logic [31:0] r;
        @(negedge clk);
        bus_addr = 4'h0;
        pad_in = 32'hFFFF_5A5A;
        @(negedge clk); #1 r = bus_rdata;
        check("R4 not after one edge", r, 32'h0);
        @(negedge clk); #1 r = bus_rdata;
        check("R4 after two edges, R6 masked", r, 32'hFFFF_5A5A & IMPL);
        bus_write(4'h0, 32'h0);
        bus_read(4'h0, r); check("R4 write ignored", r, 32'hFFFF_5A5A & IMPL);
        check("R4 write leaves latch", pad_out, exp_out);
    endtask

    task automatic t_alt();
        logic [31:0] r;
        bus_write(4'h4, 32'hE4E4_1B93);
        bus_read(4'h4, r); check("R5 alt low read", r, 32'hE4E4_1B93);
        check("R5 alt low pins", alt_sel[31:0], 32'hE4E4_1B93);
        check("R5 pin 1 code", alt_sel[3:2], 2'b00);
        bus_write(4'h5, 32'hFFFF_FFFF);
        bus_read(4'h5, r); check("R6 alt high masked", r, 32'h0000_03FF);
        check("R5 alt high pins", alt_sel, {32'h0000_03FF, 32'hE4E4_1B93});
        bus_write(4'h5, 32'h0000_0204);
        check("R5 pin 17 and 20 codes", alt_sel[63:32], 32'h0000_0204);
    endtask

    task automatic t_unimpl();
        logic [31:0] r;
        bus_write(4'h2, 32'hFFE0_0000);
        check("R6 set upper ignored", pad_out, exp_out);
        bus_write(4'h1, 32'hFFFF_FFFF);
        bus_read(4'h1, r); check("R6 dir masked", r, IMPL);
        check("R6 pad_oe masked", pad_oe, IMPL);
        bus_write(4'h2, 32'hFFFF_FFFF); exp_out = IMPL;
        check("R1 all set, R6 masked", pad_out, exp_out);
        bus_write(4'h3, 32'h0010_0001); exp_out = IMPL & ~32'h0010_0001;
        check("R2 edge pins cleared", pad_out, exp_out);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_set_clear();
        t_dir_hold();
        t_read_zero();
        t_level();
        t_alt();
        t_unimpl();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule